// File: doc/BRIEF.md
# Watermark DMA Request Generator

This block sits next to the data buffer of a storage host controller and tells an external DMA engine when to move data. In the write direction it asks for a transfer once the buffer has room for a programmed number of words. In the read direction it asks once the buffer holds a programmed number of words. It only raises a request when the controller's own DMA engine is idle and software has enabled external requests.

Every access to the data port register pulls the request low in the same cycle. The request stays low for the following cycle, which gives the fill level time to settle. After that it comes back only if the threshold still holds. Two sticky status flags, one per direction, record each new request when their enable bits allow it. Software clears them by writing one.

All pins are plain control and status signals. No data passes through the block, so it has no valid/ready handshake.

Top module: `wm_dma_req`

## Requirements
- R1: `dma_req` stays low whenever, in the previous cycle, `ext_dma_en` was 0 or `int_dma_busy` was 1.
- R2: In the write direction (`dir_rd`=0), the request condition is that free space is at least the write threshold. Free space is `buf_depth - fill_lvl`, and it is 0 when `fill_lvl > buf_depth`.
- R3: In the read direction (`dir_rd`=1), the request condition is that `fill_lvl` is at least the read threshold.
- R4: In any cycle where `port_acc` is 1, `dma_req` is 0 in that same cycle.
- R5: After a cycle with `port_acc`=1, `dma_req` stays 0 for one further cycle. It then rises if the condition of R1–R3 held in the cycle before.
- R6: When `dir_rd` differs from its value in the previous cycle, `dma_req` is 0 in the next cycle.
- R7: `wr_rdy` is set in the cycle after the request register rises in the write direction, provided `wr_rdy_en` is 1.
- R8: `rd_rdy` is set in the cycle after the request register rises in the read direction, provided `rd_rdy_en` is 1. A rise in either direction leaves the flag of the other direction, and any flag whose enable is 0, unchanged.
- R9: `wr_rdy_clr` and `rd_rdy_clr` clear their flag in the next cycle. When a set and a clear arrive in the same cycle, the set wins.
- R10: A threshold value of 0 behaves as 1.
- R11: Otherwise the request register follows the condition with one cycle of delay. Reset leaves `dma_req`, `wr_rdy` and `rd_rdy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_lvl | input | LVL_W | Words currently held in the buffer |
| buf_depth | input | LVL_W | Buffer capacity in words |
| rd_thresh | input | LVL_W | Read threshold in words (0 means 1) |
| wr_thresh | input | LVL_W | Write threshold in words (0 means 1) |
| dir_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| int_dma_busy | input | 1 | Internal DMA engine in use |
| ext_dma_en | input | 1 | External DMA requests enabled |
| wr_rdy_en | input | 1 | Enable for the write-ready status flag |
| rd_rdy_en | input | 1 | Enable for the read-ready status flag |
| port_acc | input | 1 | Data port register accessed this cycle |
| wr_rdy_clr | input | 1 | Write-one strobe that clears `wr_rdy` |
| rd_rdy_clr | input | 1 | Write-one strobe that clears `rd_rdy` |
| dma_req | output | 1 | DMA request to the system |
| wr_rdy | output | 1 | Sticky write-ready status |
| rd_rdy | output | 1 | Sticky read-ready status |

## Verification
The bench pushes both thresholds to the exact boundary and one word short of it. A comparison that is off by one would show up as a request raised or withheld one word early. It also tests a zero threshold, and a fill level above the depth, where a wrapping subtraction would produce a false request. It issues single and back-to-back port accesses and flips the direction while both conditions hold. It clears a flag in the same cycle as a new request. A design with no post-access gap, with a sticky flag that loses its set, or with a request that carries across a direction change would all differ from the cycle model.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_dir_e;

  localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/wm_level_cmp.sv
module wm_level_cmp #(
  parameter int unsigned LVL_W = 8
) (
  input  logic [LVL_W-1:0] fill_i,
  input  logic [LVL_W-1:0] depth_i,
  input  logic [LVL_W-1:0] rd_th_i,
  input  logic [LVL_W-1:0] wr_th_i,
  input  logic             dir_rd_i,
  output logic             met_o
);
  localparam logic [LVL_W-1:0] ONE = {{(LVL_W-1){1'b0}}, 1'b1};

  logic [LVL_W-1:0] free_w;
  logic [LVL_W-1:0] rd_eff;
  logic [LVL_W-1:0] wr_eff;

  always_comb begin
    free_w = (fill_i > depth_i) ? '0 : (depth_i - fill_i);
    rd_eff = (rd_th_i == '0) ? ONE : rd_th_i;
    wr_eff = (wr_th_i == '0) ? ONE : wr_th_i;
    met_o  = dir_rd_i ? (fill_i >= rd_eff) : (free_w >= wr_eff);
  end
endmodule

// File: rtl/wm_req_ctl.sv
module wm_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic met_i,
  input  logic dir_rd_i,
  input  logic port_acc_i,
  output logic req_o,
  output logic rise_o
);
  logic req_q;
  logic dir_q;
  logic req_nxt;

  always_comb begin
    req_nxt = met_i && !port_acc_i && (dir_rd_i == dir_q);
    rise_o  = req_nxt && !req_q;
    req_o   = req_q && !port_acc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
      dir_q <= dir_rd_i;
    end
  end

  // R5
  acc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(port_acc_i) |-> !req_o);

  // R6
  dir_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd_i != dir_q) |=> !req_q);
endmodule

// File: rtl/wm_sts_flag.sv
module wm_sts_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R7
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R9
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/wm_dma_req.sv
module wm_dma_req #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic [LVL_W-1:0] buf_depth,
  input  logic [LVL_W-1:0] rd_thresh,
  input  logic [LVL_W-1:0] wr_thresh,
  input  logic             dir_rd,
  input  logic             int_dma_busy,
  input  logic             ext_dma_en,
  input  logic             wr_rdy_en,
  input  logic             rd_rdy_en,
  input  logic             port_acc,
  input  logic             wr_rdy_clr,
  input  logic             rd_rdy_clr,
  output logic             dma_req,
  output logic             wr_rdy,
  output logic             rd_rdy
);
  import wm_pkg::*;

  logic               lvl_met;
  logic               met_gated;
  logic               req_rise;
  logic [NUM_DIR-1:0] sts_set;
  logic [NUM_DIR-1:0] sts_clr;
  logic [NUM_DIR-1:0] sts_en;
  logic [NUM_DIR-1:0] sts_q;

  wm_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .fill_i   (fill_lvl),
    .depth_i  (buf_depth),
    .rd_th_i  (rd_thresh),
    .wr_th_i  (wr_thresh),
    .dir_rd_i (dir_rd),
    .met_o    (lvl_met)
  );

  assign met_gated = lvl_met && ext_dma_en && !int_dma_busy;

  wm_req_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .met_i      (met_gated),
    .dir_rd_i   (dir_rd),
    .port_acc_i (port_acc),
    .req_o      (dma_req),
    .rise_o     (req_rise)
  );

  assign sts_en  = {rd_rdy_en, wr_rdy_en};
  assign sts_clr = {rd_rdy_clr, wr_rdy_clr};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_sts
    localparam xfer_dir_e DIR = (d == 0) ? XFER_WR : XFER_RD;
    assign sts_set[d] = req_rise && sts_en[d] && (dir_rd == DIR);
    wm_sts_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sts_set[d]),
      .clr_i  (sts_clr[d]),
      .flag_o (sts_q[d])
    );
  end

  assign wr_rdy = sts_q[0];
  assign rd_rdy = sts_q[1];

  // R1
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ext_dma_en && !int_dma_busy) |-> !dma_req);

  // R4
  acc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_acc |-> !dma_req);

  // R8
  sts_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot0(sts_set) |-> 1'b0);
endmodule

// File: tb/wm_dma_req_test.sv
module wm_dma_req_test;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] fill_lvl = '0, buf_depth = 8'd16, rd_thresh = '0, wr_thresh = '0;
  logic dir_rd = 1'b0, int_dma_busy = 1'b0, ext_dma_en = 1'b0;
  logic wr_rdy_en = 1'b0, rd_rdy_en = 1'b0, port_acc = 1'b0;
  logic wr_rdy_clr = 1'b0, rd_rdy_clr = 1'b0;
  logic dma_req, wr_rdy, rd_rdy;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R11";

  // reference state
  bit m_req = 0, m_dir = 0, m_wr = 0, m_rd = 0;

  always #10 clk = ~clk;

  wm_dma_req #(.LVL_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .buf_depth(buf_depth),
    .rd_thresh(rd_thresh), .wr_thresh(wr_thresh), .dir_rd(dir_rd),
    .int_dma_busy(int_dma_busy), .ext_dma_en(ext_dma_en),
    .wr_rdy_en(wr_rdy_en), .rd_rdy_en(rd_rdy_en), .port_acc(port_acc),
    .wr_rdy_clr(wr_rdy_clr), .rd_rdy_clr(rd_rdy_clr),
    .dma_req(dma_req), .wr_rdy(wr_rdy), .rd_rdy(rd_rdy)
  );

  function automatic bit cond_now();
    int f, d, rt, wt, fr;
    f = fill_lvl; d = buf_depth;
    rt = (rd_thresh == 0) ? 1 : rd_thresh;
    wt = (wr_thresh == 0) ? 1 : wr_thresh;
    fr = (f > d) ? 0 : d - f;
    if (!ext_dma_en || int_dma_busy) return 0;
    return dir_rd ? (f >= rt) : (fr >= wt);
  endfunction

  task automatic chk(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit nreq, rise;
    @(posedge clk);
    nreq = cond_now() && !port_acc && (dir_rd == m_dir);
    rise = nreq && !m_req;
    if (rise && !dir_rd && wr_rdy_en) m_wr = 1; else if (wr_rdy_clr) m_wr = 0;
    if (rise && dir_rd && rd_rdy_en)  m_rd = 1; else if (rd_rdy_clr) m_rd = 0;
    m_req = nreq;
    m_dir = dir_rd;
    @(negedge clk);
    chk(dma_req, m_req && !port_acc, "dma_req");
    chk(wr_rdy, m_wr, "wr_rdy");
    chk(rd_rdy, m_rd, "rd_rdy");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R11";
    chk(dma_req, 0, "reset dma_req");
    chk(wr_rdy, 0, "reset wr_rdy");
    chk(rd_rdy, 0, "reset rd_rdy");
    rst_n = 1'b1;
    wr_thresh = 8'd4; rd_thresh = 8'd8;
    run(3);

    // R1: disabled, then enabled with internal DMA busy
    tag = "R1";
    wr_rdy_en = 1; rd_rdy_en = 1;
    run(3);
    ext_dma_en = 1; int_dma_busy = 1;
    run(3);
    int_dma_busy = 0;
    run(3);
    ext_dma_en = 0;
    run(2);
    ext_dma_en = 1;
    run(2);

    // R2: write boundary, free == thresh, then one short, then overfilled
    tag = "R2";
    fill_lvl = 8'd12; run(3);
    fill_lvl = 8'd13; run(3);
    fill_lvl = 8'd20; run(3);
    fill_lvl = 8'd12; run(2);

    // R10: zero threshold acts as one
    tag = "R10";
    wr_thresh = 0; fill_lvl = 8'd16; run(3);
    fill_lvl = 8'd15; run(3);
    wr_thresh = 8'd4; fill_lvl = 8'd0; run(2);

    // R4 / R5: single access then back-to-back accesses
    tag = "R4";
    port_acc = 1; run(1);
    port_acc = 0;
    tag = "R5";
    run(3);
    tag = "R4";
    port_acc = 1; run(3);
    port_acc = 0;
    tag = "R5";
    run(3);
    port_acc = 1; fill_lvl = 8'd14; run(1);
    port_acc = 0; run(3);

    // R6: direction flip while both conditions hold
    tag = "R6";
    fill_lvl = 8'd8; run(2);
    dir_rd = 1; run(3);
    dir_rd = 0; run(3);
    dir_rd = 1;

    // R3: read boundary
    tag = "R3";
    fill_lvl = 8'd7; run(3);
    fill_lvl = 8'd8; run(3);
    rd_thresh = 0; fill_lvl = 8'd1; run(2);
    fill_lvl = 8'd0; run(2);
    rd_thresh = 8'd8;

    // R9: clears, including clear together with a new rise
    tag = "R9";
    rd_rdy_clr = 1; wr_rdy_clr = 1; run(1);
    rd_rdy_clr = 0; wr_rdy_clr = 0; run(2);
    fill_lvl = 8'd9; run(1);
    port_acc = 1; run(1);
    port_acc = 0; rd_rdy_clr = 1; run(1);
    run(1);
    rd_rdy_clr = 0; run(2);

    // R7 / R8: enables off, rise does not set flags
    tag = "R8";
    rd_rdy_en = 0; rd_rdy_clr = 1; run(1);
    rd_rdy_clr = 0; port_acc = 1; run(1);
    port_acc = 0; run(3);
    tag = "R7";
    dir_rd = 0; fill_lvl = 8'd0; wr_rdy_en = 0; wr_rdy_clr = 1; run(1);
    wr_rdy_clr = 0; run(3);
    port_acc = 1; run(1);
    port_acc = 0; wr_rdy_en = 1; run(3);
    port_acc = 1; run(1);
    port_acc = 0; run(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule